// File: doc/BRIEF.md
# Saturating Event Counter Bank

This block keeps one counter per event line. A packet controller raises single-cycle strobes on an event vector, one bit per kind of transfer (memory, configuration or I/O reads and writes, for example). While counting is enabled, every strobe bit that is high adds one to its own counter. A counter that reaches all-ones stays there. It never wraps back to zero.

Firmware drives the bank through an APB slave. A control word holds an enable flag and a clear flag. While the clear flag is set, every counter reads zero, whatever events or writes arrive. Each counter can be read, and each can be written. Writing a value such as one just below the maximum lets software test saturation quickly. Transfers finish with no wait states. An access to an address the map does not define raises the slave error.

Top module: `evt_count_bank`

## Requirements
- R1: After reset the control word reads 0 and every counter reads 0.
- R2: While enable is 1 and clear is 0, each event bit that is 1 in a cycle adds exactly one to its own counter. Other counters do not change.
- R3: A counter at 0xFFFF stays at 0xFFFF on further events and never returns to zero.
- R4: While enable is 0, event pulses leave every counter unchanged.
- R5: While clear is 1, every counter reads 0, including when events arrive with enable set.
- R6: An APB write presets the addressed counter to pwdata[15:0]. If an event for that counter occurs in the same cycle, the written value wins.
- R7: While clear is 1, a write to a counter has no effect, and the counter stays 0.
- R8: Offset 0x00 is the control word, with bit 0 as enable and bit 1 as clear; it reads back in the same bits. Counter k is at offset 0x04 + 4*k, returned zero-extended in prdata[15:0].
- R9: pready is always 1. A transfer to an offset above 0x04 + 4*(N-1), or to an offset that is not word-aligned, sets pslverr, reads 0 and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | APB clock, also used for counting |
| presetn | input | 1 | Active-low synchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | 1 for a write transfer |
| paddr | input | ADDR_W | Byte offset |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data |
| pready | output | 1 | Transfer done, always 1 |
| pslverr | output | 1 | Unmapped access |
| evt_strobe | input | NUM_EVT | One-cycle event pulses, one bit per counter |

## Verification
The hardest case to reach from the ports is a counter write that lands in the same cycle as an event for that same counter. The bench handles this by pulsing the event bit during the access phase of the APB write. Saturation would take 65535 events to reach from zero, so the bench first presets a counter to 0xFFFD. It then pulses that counter past 0xFFFF and checks that the value holds. The case where clear overrides both a counter write and events is reached by holding clear through a write followed by event pulses.

// File: rtl/evt_count_bank.sv
module evt_count_bank #(
  parameter int NUM_EVT = 18,
  parameter int CNT_W   = 16,
  parameter int ADDR_W  = 8
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  output logic              pready,
  output logic              pslverr,
  input  logic [NUM_EVT-1:0] evt_strobe
);
  localparam int WORD_W = ADDR_W - 2;
  localparam int LAST_OFF = 4 * NUM_EVT;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic en_q, clr_q;
  logic [CNT_W-1:0] cnt [NUM_EVT];
  logic [31:0] rdata;

  wire [WORD_W-1:0] word = paddr[ADDR_W-1:2];
  wire acc    = psel & penable;
  wire mapped = (paddr[1:0] == 2'b00) && (paddr <= ADDR_W'(LAST_OFF));
  wire wr_en  = acc & pwrite & mapped;
  wire ctl_wr = wr_en && (word == '0);
  wire unused_bits = &{1'b0, pwdata};

  assign pready  = 1'b1;
  assign pslverr = acc & ~mapped;
  assign prdata  = mapped ? rdata : 32'd0;

  always_ff @(posedge pclk) begin
    if (!presetn) begin
      en_q  <= 1'b0;
      clr_q <= 1'b0;
    end else if (ctl_wr) begin
      en_q  <= pwdata[0];
      clr_q <= pwdata[1];
    end
  end

  always_comb begin
    rdata = '0;
    if (word == '0) rdata = {30'd0, clr_q, en_q};
    for (int k = 0; k < NUM_EVT; k++)
      if (word == WORD_W'(k + 1)) rdata = 32'(cnt[k]);
  end

  for (genvar k = 0; k < NUM_EVT; k++) begin : g_cnt
    wire hit = wr_en && (word == WORD_W'(k + 1));

    always_ff @(posedge pclk) begin
      if (!presetn)                                   cnt[k] <= '0;
      else if (clr_q)                                 cnt[k] <= '0;
      else if (hit)                                   cnt[k] <= pwdata[CNT_W-1:0];
      else if (en_q && evt_strobe[k] && cnt[k] != CNT_MAX) cnt[k] <= cnt[k] + 1'b1;
    end

    p_count_up_r2: assert property (@(posedge pclk) disable iff (!presetn)
      en_q && !clr_q && !hit && evt_strobe[k] && cnt[k] != CNT_MAX |=> cnt[k] == $past(cnt[k]) + 1'b1);
    p_no_wrap_r3: assert property (@(posedge pclk) disable iff (!presetn)
      cnt[k] == CNT_MAX && !clr_q && !hit |=> cnt[k] == CNT_MAX);
    p_idle_hold_r4: assert property (@(posedge pclk) disable iff (!presetn)
      !en_q && !clr_q && !hit |=> $stable(cnt[k]));
    p_clear_zero_r5: assert property (@(posedge pclk) disable iff (!presetn)
      clr_q |=> cnt[k] == '0);
    p_preset_r6: assert property (@(posedge pclk) disable iff (!presetn)
      hit && !clr_q |=> cnt[k] == $past(pwdata[CNT_W-1:0]));
  end

  p_ctrl_load_r8: assert property (@(posedge pclk) disable iff (!presetn)
    ctl_wr |=> en_q == $past(pwdata[0]) && clr_q == $past(pwdata[1]));
  p_err_quiet_r9: assert property (@(posedge pclk) disable iff (!presetn)
    pslverr |-> prdata == 32'd0 && !ctl_wr);
endmodule

// File: tb/evt_count_bank_test.sv
`timescale 1ns/1ps
module evt_count_bank_test;
  localparam int N = 18;
  logic clk = 1'b0, rstn = 1'b0;
  logic psel = 0, penable = 0, pwrite = 0;
  logic [7:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic pready, pslverr;
  logic [N-1:0] evt = '0;
  int errors = 0, checks = 0;
  int exp_cnt [N];
  bit en_m = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  evt_count_bank uut (.pclk(clk), .presetn(rstn), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .pready(pready), .pslverr(pslverr), .evt_strobe(evt));

  localparam logic [N-1:0] PAT [6] = '{18'h3FFFF, 18'h00001, 18'h20000,
                                       18'h15555, 18'h2AAAA, 18'h0F0F0};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic apb(input bit wr, input logic [7:0] a, input logic [31:0] d,
                     input logic [N-1:0] e, output logic [31:0] rd, output logic err);
    @(negedge clk);
    psel = 1; penable = 0; pwrite = wr; paddr = a; pwdata = d;
    @(negedge clk);
    penable = 1; evt = e;
    #1; rd = prdata; err = pslverr;
    @(negedge clk);
    psel = 0; penable = 0; pwrite = 0; evt = '0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    logic [31:0] r; logic e;
    apb(1, a, d, '0, r, e);
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] expv);
    logic [31:0] r; logic e;
    apb(0, a, 32'd0, '0, r, e);
    chk(req, r, expv);
  endtask

  task automatic pulse(input logic [N-1:0] v);
    @(negedge clk); evt = v;
    @(negedge clk); evt = '0;
    for (int j = 0; j < N; j++)
      if (en_m && v[j] && exp_cnt[j] < 65535) exp_cnt[j]++;
  endtask

  task automatic chk_all(input string req);
    for (int j = 0; j < N; j++) rd_chk(req, 8'(4 + 4*j), 32'(exp_cnt[j]));
  endtask

  initial begin
    #1ms;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] r; logic e;
    for (int j = 0; j < N; j++) exp_cnt[j] = 0;
    repeat (4) @(negedge clk);
    rstn = 1;
    rd_chk("R1 ctrl", 8'h00, 32'd0);
    rd_chk("R1 cnt0", 8'h04, 32'd0);
    rd_chk("R1 cnt17", 8'h48, 32'd0);
    chk("R9 pready", 32'(pready), 32'd1);

    wr(8'h00, 32'd1); en_m = 1;
    rd_chk("R8 ctrl enable", 8'h00, 32'd1);
    for (int i = 0; i < 6; i++) pulse(PAT[i]);
    chk_all("R2 pattern walk");

    wr(8'h00, 32'd0); en_m = 0;
    pulse('1); pulse('1); pulse(18'h00F00);
    chk_all("R4 disabled hold");

    wr(8'h00, 32'd1); en_m = 1;
    wr(8'h18, 32'hABCDFFFD); exp_cnt[5] = 32'hFFFD;
    rd_chk("R8 zero-extend", 8'h18, 32'h0000FFFD);
    for (int i = 0; i < 4; i++) pulse(18'h00020);
    rd_chk("R3 saturate", 8'h18, 32'h0000FFFF);
    pulse(18'h00020);
    rd_chk("R3 no rollover", 8'h18, 32'h0000FFFF);

    apb(1, 8'h0C, 32'h1234, 18'h00004, r, e); exp_cnt[2] = 32'h1234;
    rd_chk("R6 write beats event", 8'h0C, 32'h1234);
    pulse(18'h00004);
    rd_chk("R6 count after preset", 8'h0C, 32'h1235);

    wr(8'h00, 32'd3);
    for (int j = 0; j < N; j++) exp_cnt[j] = 0;
    en_m = 0;
    rd_chk("R8 ctrl clear", 8'h00, 32'd3);
    pulse('1); pulse(18'h2AAAA);
    chk_all("R5 clear held");
    wr(8'h10, 32'h55);
    rd_chk("R7 write under clear", 8'h10, 32'd0);

    wr(8'h00, 32'd1); en_m = 1;
    pulse(18'h00001);
    rd_chk("R5 release clear", 8'h04, 32'd1);

    apb(0, 8'h4C, 32'd0, '0, r, e);
    chk("R9 err past end", 32'(e), 32'd1);
    chk("R9 err read zero", r, 32'd0);
    apb(1, 8'h01, 32'd0, '0, r, e);
    chk("R9 err misaligned", 32'(e), 32'd1);
    rd_chk("R9 misaligned write ignored", 8'h00, 32'd1);
    apb(0, 8'h48, 32'd0, '0, r, e);
    chk("R9 no err last counter", 32'(e), 32'd0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule